// File: doc/BRIEF.md
# DMA Interrupt Summary Aggregator

This block collects the interrupt sources of an Ethernet DMA engine into one level-sensitive interrupt line. Single-cycle event pulses from the DMA set individual source bits in a status register. A companion enable register decides which sources feed two sticky summary bits. One summary covers the normal sources and the other covers the abnormal ones. The interrupt output is the enabled OR of those two summary bits only.

Software uses a small register port. A one-bit select picks the status register or the enable register. Reads are combinational. Status bits are cleared by writing 1 to them. Summaries and the interrupt line are re-evaluated only when a register is written, and every write to either register triggers that evaluation. Between writes, events still set source bits, but the summaries and the interrupt line hold their values. A status write that has any read-only bit set produces a one-cycle error pulse.

Top module: `dma_irq_summary`

## Requirements
- R1: On any register write, if a source in the normal group (status bits 0, 2, 6, 14) is set and its enable bit is set after that write, status bit 16 (normal summary) is 1 from the next cycle.
- R2: On any register write, if a source in the abnormal group (status bits 1, 3, 4, 5, 7, 8, 9, 10, 13) is set and enabled after that write, status bit 15 (abnormal summary) is 1 from the next cycle.
- R3: A summary bit is never cleared by evaluation. Only writing 1 to it clears it, and in that same write it is set again if its group condition still holds.
- R4: After each write, irq_o equals (bit 16 AND enable bit 16) OR (bit 15 AND enable bit 15), using the register values that result from that write.
- R5: An event sets its source bit (status bit i for evt_i[i]) in the next cycle. Neither summary bit nor irq_o changes until the next register write.
- R6: Writing 1 to any of status bits 16:0 clears that bit, and writing 0 leaves it unchanged. Bits 11 and 12 belong to neither group and never affect a summary.
- R7: Status bits 31:17 always read 0. A status write with any of those bits set drives wr_err_o high for exactly the following cycle.
- R8: When an event and a clearing write hit the same source bit in the same cycle, the bit ends up set.
- R9: After reset, both registers read 0 and irq_o and wr_err_o are 0. The enable register stores and returns all 32 written bits (reg_addr_i = 1), and the status register is at reg_addr_i = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 15 | One-cycle set pulses for status bits 14:0 |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 status, 1 enable |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data for the selected register |
| wr_err_o | output | 1 | One-cycle pulse after a status write that touched read-only bits |
| irq_o | output | 1 | Level interrupt output |

## Verification
The assertions assume that reg_wr_i is a single-cycle strobe sampled at the clock edge. They also assume that evt_i and the write fields are 0 whenever reset is active, so the first check after reset sees settled values. The bench drives every input on the falling edge, holds it for exactly one cycle and then returns it to zero. All inputs are 0 while reset is asserted. Cases where an event and a clearing write fall in the same cycle are created on purpose, because priority between them is defined behaviour.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_ENABLE = 1'b1
  } irq_reg_sel_e;

  localparam int          DEF_SRC_W    = 15;
  localparam logic [14:0] DEF_NORM_GRP = 15'h4045;  // bits 0,2,6,14
  localparam logic [14:0] DEF_ABN_GRP  = 15'h27BA;  // bits 1,3,4,5,7,8,9,10,13

endpackage

// File: rtl/dma_irq_grp_hit.sv
module dma_irq_grp_hit #(
  parameter int             SRC_W = 15,
  parameter logic [SRC_W-1:0] GRP = '0
) (
  input  logic [SRC_W-1:0] src_i,
  input  logic [SRC_W-1:0] en_i,
  output logic             hit_o
);

  logic [SRC_W-1:0] term;

  for (genvar i = 0; i < SRC_W; i++) begin : g_term
    if (GRP[i]) begin : g_member
      assign term[i] = src_i[i] & en_i[i];
    end else begin : g_other
      assign term[i] = 1'b0;
    end
  end

  assign hit_o = |term;

endmodule

// File: rtl/dma_irq_src_bits.sv
module dma_irq_src_bits #(
  parameter int SRC_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] evt_i,
  input  logic [SRC_W-1:0] clr_i,
  output logic [SRC_W-1:0] src_q_o,
  output logic [SRC_W-1:0] src_d_o
);

  logic [SRC_W-1:0] src_q;
  logic [SRC_W-1:0] src_d;
  logic             src_ce;

  // event wins over a same-cycle clear
  for (genvar i = 0; i < SRC_W; i++) begin : g_bit
    assign src_d[i] = evt_i[i] | (src_q[i] & ~clr_i[i]);
  end

  assign src_ce = (|evt_i) | (|clr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
    end else if (src_ce) begin
      src_q <= src_d;
    end
  end

  assign src_q_o = src_q;
  assign src_d_o = src_d;

  // R8: every pulsed bit is set one cycle later
  p_evt_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((src_q & $past(evt_i)) == $past(evt_i)));

  // R6: a source bit only rises through an event
  p_rise_needs_evt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((src_q & ~$past(src_q) & ~$past(evt_i)) == '0));

endmodule

// File: rtl/dma_irq_sum_bit.sv
module dma_irq_sum_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic eval_i,
  input  logic clr_i,
  input  logic hit_i,
  output logic q_o,
  output logic d_o
);

  logic sum_q;
  logic sum_d;

  always_comb begin
    sum_d = (sum_q & ~clr_i) | (eval_i & hit_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= 1'b0;
    end else if (eval_i) begin
      sum_q <= sum_d;
    end
  end

  assign q_o = sum_q;
  assign d_o = sum_d;

  // R3: without an explicit clear the summary never falls
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_q && !clr_i) |=> sum_q);

  // R1 / R2 (per instance): an evaluation that sees its group hit sets the bit
  p_hit_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && hit_i) |=> sum_q);

endmodule

// File: rtl/dma_irq_summary.sv
module dma_irq_summary
  import dma_irq_pkg::*;
#(
  parameter int               DATA_W   = 32,
  parameter int               SRC_W    = DEF_SRC_W,
  parameter logic [SRC_W-1:0] NORM_GRP = DEF_NORM_GRP,
  parameter logic [SRC_W-1:0] ABN_GRP  = DEF_ABN_GRP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_W-1:0]  evt_i,
  input  logic              reg_wr_i,
  input  logic              reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              wr_err_o,
  output logic              irq_o
);

  localparam int AIS_IDX = SRC_W;
  localparam int NIS_IDX = SRC_W + 1;
  localparam int WR_W    = SRC_W + 2;
  localparam int RO_W    = DATA_W - WR_W;

  logic              wr_status;
  logic              wr_enable;
  logic [WR_W-1:0]   clr_vec;
  logic [DATA_W-1:0] en_q;
  logic [DATA_W-1:0] en_d;
  logic [SRC_W-1:0]  src_q;
  logic [SRC_W-1:0]  src_d;
  logic              norm_hit;
  logic              abn_hit;
  logic              nis_q;
  logic              nis_d;
  logic              ais_q;
  logic              ais_d;
  logic              irq_q;
  logic              irq_d;
  logic              err_q;
  logic              err_d;

  // ---------------- write decode ----------------
  always_comb begin
    wr_status = reg_wr_i & (reg_addr_i == SEL_STATUS);
    wr_enable = reg_wr_i & (reg_addr_i == SEL_ENABLE);
    clr_vec   = wr_status ? reg_wdata_i[WR_W-1:0] : '0;
    en_d      = wr_enable ? reg_wdata_i : en_q;
    err_d     = wr_status & (|reg_wdata_i[DATA_W-1:WR_W]);
  end

  // ---------------- enable register ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (wr_enable) begin
      en_q <= en_d;
    end
  end

  // ---------------- source bits ----------------
  dma_irq_src_bits #(.SRC_W(SRC_W)) u_src (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (evt_i),
    .clr_i   (clr_vec[SRC_W-1:0]),
    .src_q_o (src_q),
    .src_d_o (src_d)
  );

  // ---------------- group evaluation on post-write values ----------------
  dma_irq_grp_hit #(.SRC_W(SRC_W), .GRP(NORM_GRP)) u_norm_hit (
    .src_i (src_d),
    .en_i  (en_d[SRC_W-1:0]),
    .hit_o (norm_hit)
  );

  dma_irq_grp_hit #(.SRC_W(SRC_W), .GRP(ABN_GRP)) u_abn_hit (
    .src_i (src_d),
    .en_i  (en_d[SRC_W-1:0]),
    .hit_o (abn_hit)
  );

  dma_irq_sum_bit u_nis (
    .clk    (clk),
    .rst_n  (rst_n),
    .eval_i (reg_wr_i),
    .clr_i  (clr_vec[NIS_IDX]),
    .hit_i  (norm_hit),
    .q_o    (nis_q),
    .d_o    (nis_d)
  );

  dma_irq_sum_bit u_ais (
    .clk    (clk),
    .rst_n  (rst_n),
    .eval_i (reg_wr_i),
    .clr_i  (clr_vec[AIS_IDX]),
    .hit_i  (abn_hit),
    .q_o    (ais_q),
    .d_o    (ais_d)
  );

  // ---------------- interrupt line and error pulse ----------------
  always_comb begin
    irq_d = (nis_d & en_d[NIS_IDX]) | (ais_d & en_d[AIS_IDX]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else if (reg_wr_i) begin
      irq_q <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  // ---------------- read mux ----------------
  always_comb begin
    if (reg_addr_i == SEL_ENABLE) begin
      reg_rdata_o = en_q;
    end else begin
      reg_rdata_o = {{RO_W{1'b0}}, nis_q, ais_q, src_q};
    end
  end

  assign irq_o    = irq_q;
  assign wr_err_o = err_q;

  // ---------------- assertions ----------------
  // R5: no write, no change of the interrupt line
  p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr_i |=> $stable(irq_o));

  // R5: no write, no change of either summary
  p_sum_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr_i |=> $stable({nis_q, ais_q}));

  // R4: a high interrupt is always backed by an enabled summary
  p_irq_backed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((nis_q & en_q[NIS_IDX]) | (ais_q & en_q[AIS_IDX])));

  // R7: error pulse only follows a status write, and lasts one cycle
  p_err_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err_o |-> $past(wr_status));

  p_err_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_err_o && !wr_status) |=> !wr_err_o);

endmodule

// File: tb/dma_irq_summary_tb.sv
module dma_irq_summary_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [14:0] evt_i;
  logic        reg_wr_i;
  logic        reg_addr_i;
  logic [31:0] reg_wdata_i;
  logic [31:0] reg_rdata_o;
  logic        wr_err_o;
  logic        irq_o;

  int checks;
  int failures;

  dma_irq_summary u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt_i),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .wr_err_o    (wr_err_o),
    .irq_o       (irq_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // one write cycle, launched on the falling edge, result visible at the next one
  task automatic wr(input logic addr, input logic [31:0] data, input logic [14:0] ev);
    reg_wr_i    = 1'b1;
    reg_addr_i  = addr;
    reg_wdata_i = data;
    evt_i       = ev;
    @(negedge clk);
    reg_wr_i    = 1'b0;
    reg_wdata_i = '0;
    evt_i       = '0;
  endtask

  task automatic pulse(input logic [14:0] ev);
    evt_i = ev;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic rd(input logic addr, output logic [31:0] data);
    reg_addr_i = addr;
    #1;
    data = reg_rdata_o;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(1'b0, v); chk("R9 status after reset", v, 32'h0);
    rd(1'b1, v); chk("R9 enable after reset", v, 32'h0);
    chk("R9 irq after reset", {31'b0, irq_o}, 32'h0);
    chk("R9 err after reset", {31'b0, wr_err_o}, 32'h0);
  endtask

  task automatic t_enable_rw;
    logic [31:0] v;
    wr(1'b1, 32'hDEAD_BEEF, '0);
    rd(1'b1, v); chk("R9 enable readback", v, 32'hDEAD_BEEF);
    wr(1'b1, 32'h0, '0);
    rd(1'b1, v); chk("R9 enable cleared", v, 32'h0);
  endtask

  task automatic t_normal;
    logic [31:0] v;
    wr(1'b1, 32'h0001_0001, '0);
    pulse(15'h0001);
    rd(1'b0, v); chk("R5 event sets source only", v, 32'h0000_0001);
    chk("R5 irq unchanged by event", {31'b0, irq_o}, 32'h0);
    wr(1'b1, 32'h0001_0001, '0);
    rd(1'b0, v); chk("R1 normal summary set by enable write", v, 32'h0001_0001);
    chk("R4 irq after normal summary", {31'b0, irq_o}, 32'h1);
  endtask

  task automatic t_sticky;
    logic [31:0] v;
    wr(1'b0, 32'h0001_0000, '0);
    rd(1'b0, v); chk("R3 summary re-set while source pending", v, 32'h0001_0001);
    chk("R3 irq stays", {31'b0, irq_o}, 32'h1);
    wr(1'b0, 32'h0000_0001, '0);
    rd(1'b0, v); chk("R3 summary kept after source clear", v, 32'h0001_0000);
    chk("R4 irq held by sticky summary", {31'b0, irq_o}, 32'h1);
    wr(1'b0, 32'h0001_0000, '0);
    rd(1'b0, v); chk("R6 summary cleared by W1C", v, 32'h0);
    chk("R4 irq low after clear", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_abnormal;
    logic [31:0] v;
    wr(1'b1, 32'h0000_A000, '0);
    pulse(15'h2801);
    wr(1'b0, 32'h0, '0);
    rd(1'b0, v); chk("R2 abnormal summary, normal not enabled", v, 32'h0000_A801);
    chk("R4 irq from abnormal summary", {31'b0, irq_o}, 32'h1);
    wr(1'b1, 32'h0000_2000, '0);
    rd(1'b0, v); chk("R3 abnormal summary survives disable", v, 32'h0000_A801);
    chk("R4 irq low when summary enable off", {31'b0, irq_o}, 32'h0);
    wr(1'b0, 32'h0001_FFFF, '0);
    rd(1'b0, v); chk("R6 clear all writable bits", v, 32'h0);
  endtask

  task automatic t_summary_masked;
    logic [31:0] v;
    wr(1'b1, 32'h0000_0001, '0);
    pulse(15'h0001);
    wr(1'b0, 32'h0, '0);
    rd(1'b0, v); chk("R1 summary set without its enable", v, 32'h0001_0001);
    chk("R4 irq gated by summary enable", {31'b0, irq_o}, 32'h0);
    wr(1'b0, 32'h0001_FFFF, '0);
  endtask

  task automatic t_readonly;
    logic [31:0] v;
    wr(1'b0, 32'hFFFE_0000, '0);
    chk("R7 error pulse", {31'b0, wr_err_o}, 32'h1);
    rd(1'b0, v); chk("R7 read-only bits stay zero", v, 32'h0);
    @(negedge clk);
    chk("R7 error pulse ends", {31'b0, wr_err_o}, 32'h0);
    pulse(15'h0001);
    wr(1'b0, 32'h0002_0001, '0);
    chk("R7 error with mixed write", {31'b0, wr_err_o}, 32'h1);
    rd(1'b0, v); chk("R6 writable part still clears", v, 32'h0);
  endtask

  task automatic t_priority;
    logic [31:0] v;
    pulse(15'h0004);
    wr(1'b0, 32'h0000_0004, 15'h0004);
    rd(1'b0, v); chk("R8 event beats clear on set bit", v, 32'h0000_0004);
    wr(1'b0, 32'h0000_0010, 15'h0010);
    rd(1'b0, v); chk("R8 event beats clear on idle bit", v, 32'h0000_0014);
    wr(1'b0, 32'h0000_0000, '0);
    rd(1'b0, v); chk("R6 writing zero keeps bits", v, 32'h0000_0014);
    wr(1'b0, 32'h0001_FFFF, '0);
  endtask

  task automatic t_ungrouped;
    logic [31:0] v;
    wr(1'b1, 32'hFFFF_FFFF, '0);
    pulse(15'h1800);
    wr(1'b0, 32'h0, '0);
    rd(1'b0, v); chk("R6 bits 11,12 feed no summary", v, 32'h0000_1800);
    chk("R6 no irq from ungrouped bits", {31'b0, irq_o}, 32'h0);
    rd(1'b1, v); chk("R9 full enable readback", v, 32'hFFFF_FFFF);
  endtask

  initial begin
    checks = 0; failures = 0;
    rst_n = 1'b0; evt_i = '0; reg_wr_i = 1'b0; reg_addr_i = 1'b0; reg_wdata_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable_rw();
    t_normal();
    t_sticky();
    t_abnormal();
    t_summary_masked();
    t_readonly();
    t_priority();
    t_ungrouped();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule